// File: doc/BRIEF.md
# Cholesky Factorization Sequencer

The block factors a small square matrix in place, following the Cholesky recurrence over integer words held in an external memory. After a start pulse it walks an outer row counter, a middle column counter that begins at the current row, and an inner counter that steps downward. For each (row, column) pair it loads the matrix element into a wide signed accumulator. It then subtracts the products of earlier factor entries and writes one result back. The result is an integer square root when the pair lies on the diagonal, and a quotient by the already computed diagonal entry when it lies below it.

One multiply-accumulate path serves every inner step. A bit-serial square-root unit and a bit-serial signed divider finish each pair. The memory uses a single linear index built from row and column bits, so no address multiplier is needed. Reads return one cycle after the address. If a diagonal accumulator is negative, or a divisor reads as zero, the run stops without further writes and reports an error together with done.

Top module: `chol_seq`

## Requirements
- R1: After reset, and before any start, `done_o`, `err_o` and `mem_we_o` are low.
- R2: Element [r][c] lives at linear address r*N+c, with r in the upper log2(N) address bits and c in the lower ones. Every write goes to an address with r >= c.
- R3: For i = 0..N-1 and j = i..N-1, the accumulator starts at [i][j] and then subtracts [i][k]*[j][k] for k = i-1 down to 0, using the values already updated in place. The block then writes floor(sqrt(acc)) to [i][i] when i = j, or acc / [i][i] truncated toward zero to [j][i] when i != j.
- R4: Every written value is saturated to the signed 16-bit range [-32768, 32767].
- R5: A negative accumulator at a diagonal step ends the run: `done_o` and `err_o` rise together and nothing more is written.
- R6: A zero diagonal value used as a divisor ends the run in the same way as R5.
- R7: `done_o` is high for exactly one cycle per run, and `mem_we_o` stays low while the block is idle.
- R8: `start_i` has no effect while a run is in progress.
- R9: A run without error makes exactly N(N+1)/2 write cycles, each a single-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when the block is idle |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | High with done_o when the run stopped on an error |
| mem_addr_o | output | 4 | Linear word address (row bits above column bits) |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| mem_wdata_o | output | 16 | Write data |
| mem_we_o | output | 1 | Write enable |

## Verification
Matrices built as L times L-transposed from small random lower-triangular factors drive the whole loop nest without errors. They confirm ordering, in-place reuse and exact square roots and quotients. Random symmetric matrices mostly hit negative diagonals at various depths and show where the run stops. Random asymmetric full-range matrices reach quotient saturation and zero divisors. Directed cases pin down saturation at both limits, a negative first element, the all-zero matrix (zero divisor) and the identity. A start pulse given mid-run must leave the result unchanged.

// File: rtl/chol_pkg.sv
package chol_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LD, S_LDW, S_RA, S_RB, S_MAC, S_FIN, S_DV0, S_SQ, S_DV, S_WR, S_DONE
  } state_t;
endpackage

// File: rtl/chol_isqrt.sv
module chol_isqrt #(
  parameter int IN_W = 40,
  localparam int OUT_W = IN_W / 2,
  localparam int CNT_W = $clog2(OUT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  rad_i,
  output logic             done_o,
  output logic [OUT_W-1:0] root_o
);
  logic [IN_W-1:0]  x_q, rad_q;
  logic [OUT_W-1:0] rem_q, root_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [OUT_W+1:0] rem_sh, trial;
  logic             ge;

  assign rem_sh = {rem_q, x_q[IN_W-1 -: 2]};
  assign trial  = {root_q, 2'b01};
  assign ge     = rem_sh >= trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; rad_q <= '0; rem_q <= '0; root_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        x_q <= rad_i; rad_q <= rad_i; rem_q <= '0; root_q <= '0;
        cnt_q <= CNT_W'(OUT_W); busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q    <= x_q << 2;
        rem_q  <= ge ? OUT_W'(rem_sh - trial) : OUT_W'(rem_sh);
        root_q <= {root_q[OUT_W-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign root_o = root_q;

  logic [IN_W+1:0] r0, r1;
  assign r0 = IN_W'(0) + (IN_W+2)'(root_q);
  assign r1 = r0 + 1'b1;
  assert_root_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (r0 * r0 <= (IN_W+2)'(rad_q)) && (r1 * r1 > (IN_W+2)'(rad_q)));
endmodule

// File: rtl/chol_div.sv
module chol_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 16,
  localparam int CNT_W = $clog2(NUM_W + 1),
  localparam int PW = NUM_W + DEN_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic signed [DEN_W-1:0] den_i,
  output logic                    done_o,
  output logic signed [NUM_W-1:0] quo_o
);
  logic [NUM_W-1:0] n_q;
  logic [DEN_W:0]   rem_q, rem_sh;
  logic [DEN_W-1:0] d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q, busy_q, done_q, ge;
  logic signed [NUM_W-1:0] num_q;
  logic signed [DEN_W-1:0] den_q;

  assign rem_sh = {rem_q[DEN_W-1:0], n_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0; rem_q <= '0; d_q <= '0; cnt_q <= '0; neg_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; num_q <= '0; den_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        n_q    <= num_i[NUM_W-1] ? NUM_W'(-num_i) : num_i;
        d_q    <= den_i[DEN_W-1] ? DEN_W'(-den_i) : den_i;
        neg_q  <= num_i[NUM_W-1] ^ den_i[DEN_W-1];
        num_q  <= num_i; den_q <= den_i;
        rem_q  <= '0; cnt_q <= CNT_W'(NUM_W); busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sh - {1'b0, d_q} : rem_sh;
        n_q   <= {n_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = neg_q ? -$signed(n_q) : $signed(n_q);

  logic signed [PW-1:0] nx, dx, rx, rabs, dabs;
  assign nx   = PW'(num_q);
  assign dx   = PW'(den_q);
  assign rx   = nx - PW'(quo_o) * dx;
  assign rabs = rx[PW-1] ? -rx : rx;
  assign dabs = dx[PW-1] ? -dx : dx;
  assert_div_trunc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rx == '0) || ((rx[PW-1] == nx[PW-1]) && (rabs < dabs)));
endmodule

// File: rtl/chol_seq.sv
module chol_seq
  import chol_pkg::*;
#(
  parameter int N     = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  localparam int IW     = $clog2(N),
  localparam int AW     = 2 * IW,
  localparam int ROOT_W = ACC_W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o
);
  localparam longint MAXL = (longint'(1) << (DW - 1)) - 1;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(MAXL);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-MAXL - 1);

  function automatic logic [DW-1:0] sat_f(input logic signed [ACC_W-1:0] v);
    if (v > MAXV) return DW'(MAXV);
    if (v < MINV) return DW'(MINV);
    return DW'(v);
  endfunction

  state_t state_q;
  logic [IW-1:0] i_q, j_q, k_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [DW-1:0]    opa_q;
  logic [DW-1:0]           res_q;
  logic                    err_q;
  logic                    diag, sq_start, dv_start, sq_done, dv_done;
  logic [ROOT_W-1:0]       sq_root;
  logic signed [ACC_W-1:0] dv_quo;
  logic signed [2*DW-1:0]  prod;

  assign diag     = (i_q == j_q);
  assign sq_start = (state_q == S_FIN) && diag && !acc_q[ACC_W-1];
  assign dv_start = (state_q == S_DV0) && (mem_rdata_i != '0);
  assign prod     = opa_q * $signed(mem_rdata_i);

  chol_isqrt #(.IN_W(ACC_W)) u_sqrt (
    .clk_i, .rst_ni, .start_i(sq_start), .rad_i(acc_q),
    .done_o(sq_done), .root_o(sq_root)
  );

  chol_div #(.NUM_W(ACC_W), .DEN_W(DW)) u_div (
    .clk_i, .rst_ni, .start_i(dv_start), .num_i(acc_q),
    .den_i($signed(mem_rdata_i)), .done_o(dv_done), .quo_o(dv_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; i_q <= '0; j_q <= '0; k_q <= '0;
      acc_q <= '0; opa_q <= '0; res_q <= '0; err_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          i_q <= '0; j_q <= '0; err_q <= 1'b0; state_q <= S_LD;
        end
        S_LD:  state_q <= S_LDW;
        S_LDW: begin
          acc_q <= {{(ACC_W-DW){mem_rdata_i[DW-1]}}, mem_rdata_i};
          if (i_q == '0) state_q <= S_FIN;
          else begin k_q <= i_q - 1'b1; state_q <= S_RA; end
        end
        S_RA: state_q <= S_RB;
        S_RB: begin opa_q <= $signed(mem_rdata_i); state_q <= S_MAC; end
        S_MAC: begin
          acc_q <= acc_q - {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
          if (k_q == '0) state_q <= S_FIN;
          else begin k_q <= k_q - 1'b1; state_q <= S_RA; end
        end
        S_FIN:
          if (!diag) state_q <= S_DV0;
          else if (acc_q[ACC_W-1]) begin err_q <= 1'b1; state_q <= S_DONE; end
          else state_q <= S_SQ;
        S_DV0:
          if (mem_rdata_i == '0) begin err_q <= 1'b1; state_q <= S_DONE; end
          else state_q <= S_DV;
        S_SQ: if (sq_done) begin
          res_q <= sat_f($signed({{(ACC_W-ROOT_W){1'b0}}, sq_root}));
          state_q <= S_WR;
        end
        S_DV: if (dv_done) begin res_q <= sat_f(dv_quo); state_q <= S_WR; end
        S_WR:
          if (j_q == IW'(N - 1)) begin
            if (i_q == IW'(N - 1)) state_q <= S_DONE;
            else begin i_q <= i_q + 1'b1; j_q <= i_q + 1'b1; state_q <= S_LD; end
          end else begin j_q <= j_q + 1'b1; state_q <= S_LD; end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o = '0;
    unique case (state_q)
      S_LD:    mem_addr_o = {i_q, j_q};
      S_RA:    mem_addr_o = {i_q, k_q};
      S_RB:    mem_addr_o = {j_q, k_q};
      S_FIN:   mem_addr_o = {i_q, i_q};
      S_WR:    mem_addr_o = {j_q, i_q};
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_we_o    = (state_q == S_WR);
  assign mem_wdata_o = mem_we_o ? res_q : '0;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = done_o && err_q;

  assert_lower_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[AW-1 -: IW] >= mem_addr_o[IW-1:0]);
  assert_diag_nonneg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[AW-1 -: IW] == mem_addr_o[IW-1:0]) |-> !mem_wdata_o[DW-1]);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !mem_we_o);
  assert_single_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_err_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !mem_we_o);
endmodule

// File: tb/test_chol_seq.sv
module test_chol_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        done_o, err_o, mem_we_o;
  logic [3:0]  mem_addr_o;
  logic [15:0] mem_rdata_i, mem_wdata_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] mem [16];
  int wr_cnt = 0;
  int bad_addr = 0;
  int init_m [16];
  int g [16];
  bit exp_err;
  int exp_wr;

  always #4 clk_i = ~clk_i;

  chol_seq i_chol_seq (.*);

  always @(posedge clk_i) begin
    if (mem_we_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
      wr_cnt++;
      if (mem_addr_o[3:2] < mem_addr_o[1:0]) bad_addr++;
    end
    mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint isq(input longint s);
    longint r = 0;
    for (int b = 20; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= s) r = t;
    end
    return r;
  endfunction

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic golden();
    g = init_m; exp_err = 0; exp_wr = 0;
    for (int i = 0; i < 4; i++)
      for (int j = i; j < 4; j++)
        if (!exp_err) begin
          longint s = g[i*4+j];
          for (int k = i - 1; k >= 0; k--) s -= longint'(g[i*4+k]) * g[j*4+k];
          if (i == j) begin
            if (s < 0) exp_err = 1;
            else begin g[i*4+i] = sat(isq(s)); exp_wr++; end
          end else begin
            if (g[i*4+i] == 0) exp_err = 1;
            else begin g[j*4+i] = sat(s / g[i*4+i]); exp_wr++; end
          end
        end
  endtask

  task automatic run_case(input bit poke_start);
    int w0, b0, cyc;
    bit seen, e;
    @(negedge clk_i);
    for (int a = 0; a < 16; a++) mem[a] = 16'(init_m[a]);
    golden();
    w0 = wr_cnt; b0 = bad_addr; seen = 0; e = 0; cyc = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!seen && cyc < 5000) begin
      if (poke_start && cyc == 7) start_i = 1'b1;  // R8 poke mid-run
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
      if (done_o) begin seen = 1; e = err_o; end
    end
    chk("R7 done seen", seen, 1);
    chk("R5/R6 err flag", e, exp_err);
    chk("R9 write count", wr_cnt - w0, exp_wr);
    chk("R2 lower-triangle writes", bad_addr - b0, 0);
    for (int a = 0; a < 16; a++) chk("R3/R4 element", $signed(mem[a]), g[a]);
    @(negedge clk_i);
    chk("R7 done one cycle", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R8 no restart / R7 idle quiet", wr_cnt - w0, exp_wr);
  endtask

  function automatic int rr(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int l [16];
    for (int a = 0; a < 16; a++) mem[a] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done after reset", done_o, 0);
    chk("R1 err after reset", err_o, 0);
    chk("R1 we after reset", mem_we_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R7 idle no write", mem_we_o, 0);

    // identity
    for (int a = 0; a < 16; a++) init_m[a] = (a % 5 == 0) ? 1 : 0;
    run_case(0);
    // all zero: zero divisor (R6)
    for (int a = 0; a < 16; a++) init_m[a] = 0;
    run_case(0);
    // negative first element (R5)
    for (int a = 0; a < 16; a++) init_m[a] = 3;
    init_m[0] = -1;
    run_case(0);
    // negative saturation (R4)
    init_m = '{1, 1, 32767, 0,  0, 2, -32768, 0,  0, 0, 9, 0,  0, 0, 0, 9};
    run_case(0);
    // positive saturation (R4)
    init_m = '{1, -1, 32767, 0,  0, 2, 32767, 0,  0, 0, 9, 0,  0, 0, 0, 9};
    run_case(0);

    // SPD from L*L^T, with start pokes (R3, R8)
    for (int t = 0; t < 60; t++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          l[r*4+c] = (c > r) ? 0 : (c == r) ? rr(1, 6) : rr(-6, 6);
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          int s = 0;
          for (int k = 0; k < 4; k++) s += l[r*4+k] * l[c*4+k];
          init_m[r*4+c] = s;
        end
      run_case(t % 2 == 0);
    end
    // random symmetric
    for (int t = 0; t < 50; t++) begin
      for (int r = 0; r < 4; r++)
        for (int c = r; c < 4; c++) begin
          init_m[r*4+c] = rr(-300, 300);
          init_m[c*4+r] = init_m[r*4+c];
        end
      run_case(0);
    end
    // random full range, small diagonals
    for (int t = 0; t < 50; t++) begin
      for (int a = 0; a < 16; a++) init_m[a] = rr(-32768, 32767);
      for (int d = 0; d < 4; d++) init_m[d*5] = rr(0, 4);
      run_case(0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule